// File: doc/BRIEF.md
# Software Interrupt Level Controller

This block keeps a 17-bit register of pending software interrupts and a 4-bit threshold (the processor interrupt level, PIL). From these it decides whether a trap should be requested, and which one. Software can change the pending register in three ways: overwrite it, set chosen bits, or clear chosen bits. Two hardware inputs can also set the two edge bits (bit 0 and bit 16). A read port returns the whole register.

Bit n, for n from 1 to 15, stands for interrupt level n. Bits 0 and 16 are extra sources at level 14. The highest pending level is compared against PIL, and the result is gated by a global enable input. The trap request is a level signal and carries a trap type code. When the trap-acknowledge input is pulsed while a request is present, the block latches that code into an output register. Acknowledging does not clear any pending bit. A handler stops the request either by clearing the pending bit or by raising PIL to 15.

Top module: `swint_level_ctrl`

## Requirements
- R1: A direct write replaces all 17 pending bits with `wr_data`. Writing 0x1FFFF reads back as 0x1FFFF on `rd_pend` after the next rising edge, and writing 0 reads back as 0.
- R2: A set-bits write ORs `wr_data` into the pending register and leaves every bit where the data is 0 unchanged.
- R3: A clear-bits write clears every pending bit where `wr_data` is 1 and leaves all other bits unchanged.
- R4: When several write strobes are high in one cycle, only one software write applies, in this priority: direct, then clear, then set. After that, `ext_set_lo` forces bit 0 to 1 and `ext_set_hi` forces bit 16 to 1.
- R5: Pending bit n (1..15) raises level n. Pending bit 0 or pending bit 16 raises level 14.
- R6: A level produces a request only when it is strictly greater than PIL. With PIL = n-1, a pending level n traps; with PIL = n, it does not. With PIL = 15, nothing traps. A PIL write takes effect after the next rising edge.
- R7: When several levels are pending, the highest level decides the request and the trap type.
- R8: `trap_req` is 0 whenever `irq_en` is 0. This holds combinationally, in the same cycle.
- R9: While `trap_req` is 1, `trap_type` equals 0x40 + level (0x41..0x4F). While `trap_req` is 0, `trap_type` is 0.
- R10: If `trap_ack` is 1 while `trap_req` is 1, the current `trap_type` appears on `taken_type` after that rising edge. If `trap_ack` arrives with no request, `taken_type` keeps its value. An acknowledge never changes the pending register.
- R11: Synchronous reset clears the pending register to 0, sets PIL to 15 and clears `taken_type` to 0. No request is present after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_direct | input | 1 | Overwrite pending register with wr_data |
| wr_set | input | 1 | OR wr_data into pending register |
| wr_clear | input | 1 | Clear pending bits where wr_data is 1 |
| wr_data | input | 17 | Data for the pending-register writes |
| ext_set_lo | input | 1 | Hardware set of pending bit 0 |
| ext_set_hi | input | 1 | Hardware set of pending bit 16 |
| pil_wr | input | 1 | Write strobe for PIL |
| pil_data | input | 4 | New PIL value |
| irq_en | input | 1 | Global interrupt enable |
| trap_ack | input | 1 | Trap taken pulse |
| rd_pend | output | 17 | Current pending register |
| pil_q | output | 4 | Current PIL |
| trap_req | output | 1 | Trap requested |
| trap_type | output | 8 | Type code of the requested trap |
| taken_type | output | 8 | Type code latched on acknowledge |

## Verification
Writes to the pending register and to PIL appear on `rd_pend` and `pil_q` one rising edge after the strobe. `trap_req` and `trap_type` follow combinationally from that registered state. `irq_en` acts on the request in the same cycle, and `taken_type` changes one edge after an accepted acknowledge. The bench holds every stimulus across exactly one rising edge. It then compares all outputs, at the following falling edge, against a behavioural model that has advanced by that same single edge. Because of this, every expected value is sampled in the cycle where the design's one register stage makes it due.

// File: rtl/swint_pkg.sv
package swint_pkg;

    localparam int PEND_W    = 17;
    localparam int LVL_W     = 4;
    localparam int TT_W      = 8;
    localparam int MAX_LVL   = (1 << LVL_W) - 1;
    localparam int ALIAS_LVL = MAX_LVL - 1;
    localparam logic [TT_W-1:0] TT_BASE = 8'h40;

    typedef enum logic [1:0] {
        WR_NONE   = 2'd0,
        WR_DIRECT = 2'd1,
        WR_CLEAR  = 2'd2,
        WR_SET    = 2'd3
    } wr_op_e;

    typedef struct packed {
        logic             req;
        logic [LVL_W-1:0] lvl;
    } sel_t;

    // one software write per cycle: direct beats clear beats set
    function automatic wr_op_e pick_op(input logic d, input logic c, input logic s);
        if (d)      return WR_DIRECT;
        else if (c) return WR_CLEAR;
        else if (s) return WR_SET;
        else        return WR_NONE;
    endfunction

    function automatic logic [TT_W-1:0] tt_of(input logic [LVL_W-1:0] l);
        return TT_BASE + TT_W'(l);
    endfunction

endpackage

// File: rtl/swint_pend_reg.sv
module swint_pend_reg
    import swint_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_op_e            op,
    input  logic [PEND_W-1:0] data,
    input  logic              ext_lo,
    input  logic              ext_hi,
    output logic [PEND_W-1:0] pend
);

    logic [PEND_W-1:0] ext_vec;
    logic [PEND_W-1:0] nxt;

    assign ext_vec = {ext_hi, {(PEND_W-2){1'b0}}, ext_lo};

    for (genvar b = 0; b < PEND_W; b++) begin : g_bit
        logic sw_bit;
        always_comb begin
            unique case (op)
                WR_DIRECT: sw_bit = data[b];
                WR_CLEAR:  sw_bit = pend[b] & ~data[b];
                WR_SET:    sw_bit = pend[b] | data[b];
                default:   sw_bit = pend[b];
            endcase
        end
        assign nxt[b] = sw_bit | ext_vec[b];
    end

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= nxt;
    end

    AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (op == WR_DIRECT && !ext_lo && !ext_hi) |=> pend == $past(data)); // R1
    AST_SET_BITS: assert property (@(posedge clk) disable iff (rst)
        (op == WR_SET) |=> (pend & $past(data)) == $past(data)); // R2
    AST_CLEAR_BITS: assert property (@(posedge clk) disable iff (rst)
        (op == WR_CLEAR && !ext_lo && !ext_hi) |=> (pend & $past(data)) == '0); // R3
    AST_EXT_EDGE: assert property (@(posedge clk) disable iff (rst)
        (ext_lo && ext_hi) |=> (pend[0] && pend[PEND_W-1])); // R4

endmodule

// File: rtl/swint_prio.sv
module swint_prio
    import swint_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PEND_W-1:0] pend,
    input  logic [LVL_W-1:0]  pil,
    input  logic              ie,
    output sel_t              sel
);

    logic [MAX_LVL:1] lvl_vec;
    logic [LVL_W-1:0] top_lvl;

    for (genvar l = 1; l <= MAX_LVL; l++) begin : g_lvl
        if (l == ALIAS_LVL) begin : g_alias
            assign lvl_vec[l] = pend[l] | pend[0] | pend[PEND_W-1];
        end else begin : g_plain
            assign lvl_vec[l] = pend[l];
        end
    end

    always_comb begin
        top_lvl = '0;
        for (int l = 1; l <= MAX_LVL; l++) begin
            if (lvl_vec[l]) top_lvl = LVL_W'(l);
        end
    end

    always_comb begin
        sel.lvl = top_lvl;
        sel.req = ie && (top_lvl != '0) && (top_lvl > pil);
    end

    AST_NO_IE: assert property (@(posedge clk) disable iff (rst)
        !ie |-> !sel.req); // R8
    AST_PIL_MASK: assert property (@(posedge clk) disable iff (rst)
        (pil == LVL_W'(MAX_LVL)) |-> !sel.req); // R6
    AST_ABOVE_PIL: assert property (@(posedge clk) disable iff (rst)
        sel.req |-> (sel.lvl > pil)); // R6
    AST_HIGHEST: assert property (@(posedge clk) disable iff (rst)
        (sel.req && pend[MAX_LVL]) |-> (sel.lvl == LVL_W'(MAX_LVL))); // R7

endmodule

// File: rtl/swint_trap_cap.sv
module swint_trap_cap
    import swint_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req,
    input  logic [TT_W-1:0] tt,
    input  logic            ack,
    output logic [TT_W-1:0] taken
);

    always_ff @(posedge clk) begin
        if (rst)             taken <= '0;
        else if (ack && req) taken <= tt;
    end

    AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (ack && req) |=> taken == $past(tt)); // R10
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(ack && req) |=> $stable(taken)); // R10

endmodule

// File: rtl/swint_level_ctrl.sv
module swint_level_ctrl
    import swint_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_direct,
    input  logic              wr_set,
    input  logic              wr_clear,
    input  logic [PEND_W-1:0] wr_data,
    input  logic              ext_set_lo,
    input  logic              ext_set_hi,
    input  logic              pil_wr,
    input  logic [LVL_W-1:0]  pil_data,
    input  logic              irq_en,
    input  logic              trap_ack,
    output logic [PEND_W-1:0] rd_pend,
    output logic [LVL_W-1:0]  pil_q,
    output logic              trap_req,
    output logic [TT_W-1:0]   trap_type,
    output logic [TT_W-1:0]   taken_type
);

    wr_op_e op;
    sel_t   sel;

    assign op = pick_op(wr_direct, wr_clear, wr_set);

    swint_pend_reg u_pend (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .data   (wr_data),
        .ext_lo (ext_set_lo),
        .ext_hi (ext_set_hi),
        .pend   (rd_pend)
    );

    always_ff @(posedge clk) begin
        if (rst)         pil_q <= LVL_W'(MAX_LVL);
        else if (pil_wr) pil_q <= pil_data;
    end

    swint_prio u_prio (
        .clk  (clk),
        .rst  (rst),
        .pend (rd_pend),
        .pil  (pil_q),
        .ie   (irq_en),
        .sel  (sel)
    );

    assign trap_req  = sel.req;
    assign trap_type = sel.req ? tt_of(sel.lvl) : '0;

    swint_trap_cap u_cap (
        .clk   (clk),
        .rst   (rst),
        .req   (trap_req),
        .tt    (trap_type),
        .ack   (trap_ack),
        .taken (taken_type)
    );

    AST_TT_RANGE: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> (trap_type > TT_BASE && trap_type <= TT_BASE + TT_W'(MAX_LVL))); // R9
    AST_TT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !trap_req |-> (trap_type == '0)); // R9
    AST_ACK_KEEPS_PEND: assert property (@(posedge clk) disable iff (rst)
        (trap_ack && !wr_direct && !wr_set && !wr_clear) |=>
            ((rd_pend & $past(rd_pend)) == $past(rd_pend))); // R10

endmodule

// File: tb/sim_swint_level_ctrl.sv
module sim_swint_level_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_direct = 0, wr_set = 0, wr_clear = 0;
    logic [16:0] wr_data = '0;
    logic        ext_set_lo = 0, ext_set_hi = 0;
    logic        pil_wr = 0;
    logic [3:0]  pil_data = '0;
    logic        irq_en = 0, trap_ack = 0;
    logic [16:0] rd_pend;
    logic [3:0]  pil_q;
    logic        trap_req;
    logic [7:0]  trap_type, taken_type;

    int errors = 0;
    int checks = 0;

    // behavioural model state
    int m_pend, m_pil, m_taken;

    always #2 clk = ~clk;

    swint_level_ctrl u0 (
        .clk(clk), .rst(rst), .wr_direct(wr_direct), .wr_set(wr_set),
        .wr_clear(wr_clear), .wr_data(wr_data), .ext_set_lo(ext_set_lo),
        .ext_set_hi(ext_set_hi), .pil_wr(pil_wr), .pil_data(pil_data),
        .irq_en(irq_en), .trap_ack(trap_ack), .rd_pend(rd_pend), .pil_q(pil_q),
        .trap_req(trap_req), .trap_type(trap_type), .taken_type(taken_type)
    );

    function automatic int m_level();
        int best = 0;
        for (int l = 1; l <= 15; l++) begin
            bit hit = ((m_pend >> l) & 1) != 0;
            if (l == 14 && ((m_pend & 32'h10001) != 0)) hit = 1;
            if (hit) best = l;
        end
        return best;
    endfunction

    function automatic bit m_req();
        int l = m_level();
        return irq_en && l != 0 && l > m_pil;
    endfunction

    function automatic int m_tt();
        return m_req() ? 32'h40 + m_level() : 0;
    endfunction

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        cmp(tag, "rd_pend",    int'(rd_pend),    m_pend);
        cmp(tag, "pil_q",      int'(pil_q),      m_pil);
        cmp(tag, "trap_req",   int'(trap_req),   int'(m_req()));
        cmp(tag, "trap_type",  int'(trap_type),  m_tt());
        cmp(tag, "taken_type", int'(taken_type), m_taken);
    endtask

    // Called at a falling edge: drive, advance one rising edge, compare.
    task automatic step(input string tag, input bit d, input bit c, input bit s,
                        input int data, input bit pw, input int pd, input bit ie,
                        input bit ack, input bit elo, input bit ehi);
        wr_direct = d; wr_clear = c; wr_set = s; wr_data = data[16:0];
        pil_wr = pw; pil_data = pd[3:0]; irq_en = ie; trap_ack = ack;
        ext_set_lo = elo; ext_set_hi = ehi;
        @(posedge clk);
        if (ack && m_req()) m_taken = m_tt();
        if (d)      m_pend = data & 32'h1FFFF;
        else if (c) m_pend = m_pend & ~data;
        else if (s) m_pend = (m_pend | data) & 32'h1FFFF;
        if (elo) m_pend = m_pend | 1;
        if (ehi) m_pend = m_pend | 32'h10000;
        if (pw) m_pil = pd;
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic idle(input string tag, input bit ie);
        step(tag, 0, 0, 0, 0, 0, 0, ie, 0, 0, 0);
    endtask

    initial begin : watchdog
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        m_pend = 0; m_pil = 15; m_taken = 0;
        compare_all("R11");                                  // reset state

        // R1: direct write of all ones then zero
        step("R1", 1, 0, 0, 32'h1FFFF, 0, 0, 1, 0, 0, 0);    // PIL=15 masks
        step("R1", 1, 0, 0, 0, 0, 0, 1, 0, 0, 0);

        // R2 / R3: set then clear preserve other bits
        step("R2", 0, 0, 1, 32'h0A50A, 0, 0, 0, 0, 0, 0);
        step("R2", 0, 0, 1, 32'h10001, 0, 0, 0, 0, 0, 0);
        step("R3", 0, 1, 0, 32'h00502, 0, 0, 0, 0, 0, 0);
        step("R3", 0, 1, 0, 32'h1FFFF, 0, 0, 0, 0, 0, 0);

        // R6 R9 R10: each level with PIL = n-1, acknowledge, then clear
        for (int n = 15; n >= 1; n--) begin
            step("R6", 0, 0, 1, 1 << n, 1, n - 1, 1, 0, 0, 0);
            step("R10", 0, 0, 0, 0, 0, 0, 1, 1, 0, 0);       // ack; pend kept
            step("R9", 0, 0, 0, 0, 1, n, 1, 0, 0, 0);        // PIL=n: strict
            step("R3", 0, 1, 0, 1 << n, 1, 15, 1, 0, 0, 0);
        end

        // R7: highest of several pending levels
        step("R7", 0, 0, 1, (1 << 3) | (1 << 9) | (1 << 5), 1, 2, 1, 0, 0, 0);
        step("R7", 0, 0, 0, 0, 1, 9, 1, 0, 0, 0);
        step("R7", 0, 0, 0, 0, 1, 4, 1, 0, 0, 0);
        // R8: enable off hides the request
        idle("R8", 0);
        step("R10", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);           // ack, no request
        idle("R8", 1);

        // R5: external sets and alias bits as level 14
        step("R5", 1, 0, 0, 0, 1, 13, 1, 0, 1, 0);
        step("R5", 0, 1, 0, 32'h00001, 0, 0, 1, 0, 0, 1);
        step("R5", 0, 0, 0, 0, 1, 14, 1, 0, 0, 0);
        step("R5", 0, 0, 1, 1 << 15, 0, 0, 1, 0, 0, 0);

        // R4: same-cycle write priority and external override
        step("R4", 1, 1, 1, 32'h00F0F, 1, 0, 1, 0, 0, 0);
        step("R4", 0, 1, 1, 32'h0000F, 0, 0, 1, 0, 0, 0);
        step("R4", 0, 1, 0, 32'h1FFFF, 0, 0, 1, 0, 1, 1);
        step("R4", 1, 0, 0, 0, 0, 0, 1, 1, 0, 0);

        // R11: reset again from a busy state
        rst = 1;
        @(posedge clk);
        m_pend = 0; m_pil = 15; m_taken = 0;
        @(negedge clk);
        rst = 0;
        compare_all("R11");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule